// File: doc/BRIEF.md
# Periodic Interrupt Timer with Debug Freeze

This block is a 16-bit down-counting modulus timer that raises a periodic interrupt request. Software programs a reload value into a modulus register and sets up a control word that carries an 8-bit interrupt level, a sticky status flag, an interrupt enable, a freeze-on-debug control and a run control. On each `step` pulse the counter decrements while the timer runs. When it reaches zero, the next pulse reloads the modulus value. The status flag sets on every pulse that brings the count to zero.

A debug controller drives `dbg_freeze`. When freezing is enabled in the control word, this input stops the counter. The status flag stays set until software writes a one to it. While the flag and the interrupt enable are both set, the request output is valid and carries the programmed level to an external priority controller. Prescaling of `step` and decoding of the level are handled outside this block.

The counter is run by a three-state machine with states OFF, RUN and HALT. The next state depends only on the current controls. OFF goes to RUN when the run bit is set, and to HALT when it is set while a freeze is active. RUN goes to HALT when the freeze control and `dbg_freeze` are both high, and to OFF when the run bit clears. HALT goes back to RUN when the freeze lifts, and to OFF when the run bit clears. The counter decrements only when the next state is RUN and `step` is high.

Top module: `pit_timer`

## Requirements
- R1: After reset, the control word, the modulus register and the counter all read zero, and `irq_valid` is low.
- R2: Register addresses: 0 is the control word, 1 is the modulus, 2 is the count (read-only) and 3 reads zero. Control bit positions (LSB numbering): [15:8] level, [7] status, [6:3] reserved, [2] interrupt enable, [1] freeze enable, [0] run. The reserved bits always read zero and ignore writes. Both registers can be read or written in any cycle.
- R3: While the timer runs, each `step` decrements the count by one. A `step` at count zero loads the modulus instead, so one period is modulus+1 steps.
- R4: The status bit sets on the clock edge of any running step whose new count is zero. This includes a reload of a zero modulus.
- R5: Writing the control word with bit 7 set clears the status bit, and writing it with bit 7 clear leaves the status bit unchanged. If a set event and a clearing write fall on the same edge, the bit stays set.
- R6: `irq_valid` is high exactly when the status bit and the interrupt enable are both set. While it is high, `irq_level` equals the level field; otherwise `irq_level` is zero.
- R7: When the freeze enable and `dbg_freeze` are both high, the count holds. When the freeze enable is clear, `dbg_freeze` has no effect.
- R8: With the run bit clear, the count holds its value.
- R9: On a cycle with `step` low, the count does not change.
- R10: A write to address 2 or 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| step | input | 1 | Decrement tick from an external prescaler |
| dbg_freeze | input | 1 | Freeze request from the debug controller |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_valid | output | 1 | Interrupt request |
| irq_level | output | 8 | Interrupt level carried with the request |

## Verification
The hardest case to reach from the ports is a set event and a clearing write on the same edge. With a normal modulus, the two meet only if the write lands on one exact cycle. The bench programs a zero modulus, so the counter raises a set event on every running step, and then issues the clearing write. The write is bound to collide with a set. The bench also runs a long stretch of pseudo-random steps, freezes and writes, including writes to the read-only address, against a behavioural model that is compared every clock.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int DATA_W   = 16;
    localparam int LVL_W    = 8;
    localparam int ADDR_W   = 2;

    // control word bit positions (LSB numbering)
    localparam int LVL_LO   = DATA_W - LVL_W;
    localparam int LVL_HI   = DATA_W - 1;
    localparam int FLAG_BIT = LVL_LO - 1;
    localparam int IE_BIT   = 2;
    localparam int FZ_BIT   = 1;
    localparam int TE_BIT   = 0;
    localparam int RSV_HI   = FLAG_BIT - 1;
    localparam int RSV_LO   = IE_BIT + 1;

    typedef enum logic [ADDR_W-1:0] {
        A_CTL  = 2'd0,
        A_MOD  = 2'd1,
        A_CNT  = 2'd2,
        A_NONE = 2'd3
    } pit_addr_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } pit_state_e;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             flag;
        logic             ie;
        logic             fz;
        logic             te;
    } pit_ctl_t;

endpackage

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             tmr_en,
    input  logic             frz_en,
    input  logic             dbg_freeze,
    input  logic [CNT_W-1:0] modulus,
    output logic [CNT_W-1:0] count,
    output logic             zero_evt,
    output pit_state_e       state
);

    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    pit_state_e       state_q, state_d;
    logic             frz_hit;
    logic             run;
    logic [CNT_W-1:0] count_q, count_d;

    assign frz_hit = frz_en && dbg_freeze;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (tmr_en) state_d = frz_hit ? ST_HALT : ST_RUN;
            end
            ST_RUN: begin
                if (!tmr_en)     state_d = ST_OFF;
                else if (frz_hit) state_d = ST_HALT;
            end
            ST_HALT: begin
                if (!tmr_en)      state_d = ST_OFF;
                else if (!frz_hit) state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs of the machine: decrement / reload and zero event
    always_comb begin
        run      = step && (state_d == ST_RUN);
        count_d  = count_q;
        zero_evt = 1'b0;
        if (run) begin
            count_d  = (count_q == CNT_ZERO) ? modulus : count_q - CNT_ONE;
            zero_evt = (count_d == CNT_ZERO);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
    assign state = state_q;

    p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |=> $stable(count_q))
        else $error("count moved while timer disabled");

    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_en && frz_en && dbg_freeze) |=> $stable(count_q))
        else $error("count moved while frozen");

    p_no_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count_q))
        else $error("count moved without step");

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && tmr_en && !(frz_en && dbg_freeze) && count_q == CNT_ZERO)
        |=> (count_q == $past(modulus)))
        else $error("reload value wrong");

    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && tmr_en && !(frz_en && dbg_freeze) && count_q != CNT_ZERO)
        |=> (count_q == $past(count_q) - CNT_ONE))
        else $error("decrement wrong");

endmodule

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_evt,
    input  logic [CNT_W-1:0]  count,
    output pit_ctl_t          ctl,
    output logic [CNT_W-1:0]  modulus,
    output logic [DATA_W-1:0] rdata
);

    pit_ctl_t          ctl_q;
    logic [CNT_W-1:0]  mod_q;
    logic              ctl_wr, mod_wr;
    logic [DATA_W-1:0] ctl_img;

    assign ctl_wr = wr_en && (addr == A_CTL);
    assign mod_wr = wr_en && (addr == A_MOD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.level <= '0;
            ctl_q.ie    <= 1'b0;
            ctl_q.fz    <= 1'b0;
            ctl_q.te    <= 1'b0;
        end else if (ctl_wr) begin
            ctl_q.level <= wdata[LVL_HI:LVL_LO];
            ctl_q.ie    <= wdata[IE_BIT];
            ctl_q.fz    <= wdata[FZ_BIT];
            ctl_q.te    <= wdata[TE_BIT];
        end
    end

    // sticky status: a set event wins over a same-edge clear
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctl_q.flag <= 1'b0;
        else if (set_evt)                   ctl_q.flag <= 1'b1;
        else if (ctl_wr && wdata[FLAG_BIT]) ctl_q.flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      mod_q <= '0;
        else if (mod_wr) mod_q <= wdata[CNT_W-1:0];
    end

    always_comb begin
        ctl_img                = '0;
        ctl_img[LVL_HI:LVL_LO] = ctl_q.level;
        ctl_img[FLAG_BIT]      = ctl_q.flag;
        ctl_img[IE_BIT]        = ctl_q.ie;
        ctl_img[FZ_BIT]        = ctl_q.fz;
        ctl_img[TE_BIT]        = ctl_q.te;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTL:   rdata = ctl_img;
            A_MOD:   rdata[CNT_W-1:0] = mod_q;
            A_CNT:   rdata[CNT_W-1:0] = count;
            default: rdata = '0;
        endcase
    end

    assign ctl     = ctl_q;
    assign modulus = mod_q;

    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[FLAG_BIT] && !set_evt) |=> !ctl_q.flag)
        else $error("status not cleared by write of one");

    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> ctl_q.flag)
        else $error("status not set by zero event");

    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.flag && !(ctl_wr && wdata[FLAG_BIT])) |=> ctl_q.flag)
        else $error("status lost without a clearing write");

endmodule

// File: rtl/pit_irq.sv
module pit_irq
    import pit_pkg::*;
(
    input  pit_ctl_t         ctl,
    output logic             irq_valid,
    output logic [LVL_W-1:0] irq_level
);

    always_comb begin
        irq_valid = ctl.flag && ctl.ie;
        irq_level = irq_valid ? ctl.level : '0;
    end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              dbg_freeze,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_valid,
    output logic [LVL_W-1:0]  irq_level
);

    localparam int CNT_W = DATA_W;

    pit_ctl_t         ctl;
    logic [CNT_W-1:0] modulus;
    logic [CNT_W-1:0] count;
    logic             zero_evt;
    pit_state_e       state;

    pit_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .set_evt (zero_evt),
        .count   (count),
        .ctl     (ctl),
        .modulus (modulus),
        .rdata   (reg_rdata)
    );

    pit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .tmr_en     (ctl.te),
        .frz_en     (ctl.fz),
        .dbg_freeze (dbg_freeze),
        .modulus    (modulus),
        .count      (count),
        .zero_evt   (zero_evt),
        .state      (state)
    );

    pit_irq u_irq (
        .ctl       (ctl),
        .irq_valid (irq_valid),
        .irq_level (irq_level)
    );

    p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.ie) |-> (!irq_valid && irq_level == '0))
        else $error("request escaped mask");

    p_state_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> $past(ctl.te))
        else $error("RUN state without run bit");

endmodule

// File: tb/pit_timer_test.sv
`timescale 1ns/1ps
module pit_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic        dbg_freeze = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq_valid;
    logic [7:0]  irq_level;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pit_timer uut (
        .clk(clk), .rst_n(rst_n), .step(step), .dbg_freeze(dbg_freeze),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_level(irq_level)
    );

    // behavioural reference
    logic [7:0]  m_lvl;
    logic        m_flag, m_ie, m_fz, m_te;
    logic [15:0] m_mod, m_cnt;

    always @(posedge clk) begin : model
        logic go;
        logic hit;
        if (!rst_n) begin
            m_lvl = 8'd0; m_flag = 1'b0; m_ie = 1'b0; m_fz = 1'b0; m_te = 1'b0;
            m_mod = 16'd0; m_cnt = 16'd0;
        end else begin
            go  = step && m_te && !(m_fz && dbg_freeze);
            hit = 1'b0;
            if (go) begin
                if (m_cnt == 16'd0) m_cnt = m_mod;
                else                m_cnt = m_cnt - 16'd1;
                hit = (m_cnt == 16'd0);
            end
            if (reg_wr && reg_addr == 2'd0) begin
                m_lvl = reg_wdata[15:8];
                m_ie  = reg_wdata[2];
                m_fz  = reg_wdata[1];
                m_te  = reg_wdata[0];
                if (reg_wdata[7]) m_flag = 1'b0;
            end
            if (reg_wr && reg_addr == 2'd1) m_mod = reg_wdata;
            if (hit) m_flag = 1'b1;
        end
    end

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        logic [15:0] e_rd;
        logic        e_v;
        if (model_on && rst_n) begin
            case (reg_addr)
                2'd0:    e_rd = {m_lvl, m_flag, 4'b0000, m_ie, m_fz, m_te};
                2'd1:    e_rd = m_mod;
                2'd2:    e_rd = m_cnt;
                default: e_rd = 16'd0;
            endcase
            e_v = m_flag && m_ie;
            check({15'd0, irq_valid}, {15'd0, e_v}, "R6 irq_valid");
            check({8'd0, irq_level}, {8'd0, (e_v ? m_lvl : 8'd0)}, "R6 irq_level");
            check(reg_rdata, e_rd, (reg_addr == 2'd2) ? "R3 count" : "R2/R4/R10 readback");
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        v = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin : stim
        logic [15:0] v1, v2;
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(reg_rdata, 16'h0000, "R1 control after reset");
        check({15'd0, irq_valid}, 16'd0, "R1 irq_valid after reset");
        rd(2'd1, v1); check(v1, 16'h0000, "R1 modulus after reset");
        rd(2'd2, v1); check(v1, 16'h0000, "R1 count after reset");
        model_on = 1'b1;

        // R2: layout, reserved bits dropped
        step = 1'b1;
        wr(2'd1, 16'd4);
        wr(2'd0, 16'hA578);
        rd(2'd0, v1); check(v1, 16'hA500, "R2 reserved bits read zero");
        wr(2'd0, 16'hA57D);
        reg_addr = 2'd2;
        idle(12); // R3/R4 via per-clock model
        reg_addr = 2'd0;

        // R5: write-one-to-clear
        @(negedge clk);
        while (!irq_valid) @(negedge clk);
        check({8'd0, irq_level}, 16'h00A5, "R6 level carried");
        wr(2'd0, 16'hA504);
        rd(2'd0, v1); check(v1, 16'hA584, "R5 write zero keeps status");
        wr(2'd0, 16'hA580);
        rd(2'd0, v1); check(v1, 16'hA500, "R5 write one clears status");
        check({15'd0, irq_valid}, 16'd0, "R6 request drops with status");

        // R8: disabled counter holds
        rd(2'd2, v1); idle(5); rd(2'd2, v2); check(v2, v1, "R8 count holds when off");

        // R10: write to count address ignored
        wr(2'd2, 16'h1234);
        rd(2'd2, v2); check(v2, v1, "R10 count write ignored");
        wr(2'd3, 16'hFFFF);
        rd(2'd1, v2); check(v2, 16'd4, "R10 unused address write ignored");

        // R9: no step, no movement
        step = 1'b0;
        wr(2'd0, 16'h0001);
        rd(2'd2, v1); idle(5); rd(2'd2, v2); check(v2, v1, "R9 count holds without step");

        // R7: freeze
        step = 1'b1;
        wr(2'd1, 16'd10);
        dbg_freeze = 1'b1;
        wr(2'd0, 16'h0003);
        rd(2'd2, v1); idle(4); rd(2'd2, v2); check(v2, v1, "R7 frozen count holds");
        wr(2'd0, 16'h0001);
        rd(2'd2, v1); idle(2); rd(2'd2, v2);
        checks++;
        if (v2 == v1) begin
            errors++;
            $display("FAIL R7: freeze not ignored, actual %h expected change from %h", v2, v1);
        end
        dbg_freeze = 1'b0;

        // R4/R5: zero modulus, set wins over clear
        wr(2'd1, 16'd0);
        idle(14);
        wr(2'd0, 16'h0081);
        rd(2'd0, v1); check(v1, 16'h0081, "R5 set wins over same-edge clear");
        check({15'd0, irq_valid}, 16'd0, "R6 masked when enable clear");
        wr(2'd0, 16'h0080);
        wr(2'd0, 16'h0080);
        rd(2'd0, v1); check(v1, 16'h0000, "R5 cleared once stopped");

        // mixed pseudo-random phase against the model
        lf = 16'hACE1;
        wr(2'd1, 16'd6);
        wr(2'd0, 16'h3C05);
        for (int i = 0; i < 600; i++) begin
            @(posedge clk); #1;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step       = lf[0] | lf[1];
            dbg_freeze = lf[5] & lf[6];
            reg_addr   = lf[9:8];
            reg_wr     = (lf[15:12] == 4'd0);
            reg_wdata  = (lf[9:8] == 2'd1) ? {13'd0, lf[4:2]} : (lf ^ 16'h3C5A);
        end
        @(posedge clk); #1;
        reg_wr = 1'b0;
        idle(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule